// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

The arbiter takes a group of level-sensitive interrupt request lines. Each line has a 4-bit programmable priority and its own mask bit. Every cycle it looks at the lines that are both asserted and unmasked and picks the one with the highest level. When two candidates hold the same level, the lower source index wins. The level of the winner is then compared with the processor's current interrupt mask level. Only a level strictly above that mask causes a request toward the processor. The request carries the winning level and an event code. The code is spaced so that a handler can use it directly as a branch offset.

A line that loses arbitration is not lost. It stays a candidate for as long as its request line is held high. When the processor accepts a request, it pulses an acknowledge. The acknowledge copies the presented code into an event code register, and that register holds until the next acceptance.

Software reaches the block through a simple write port:
- Masking is done with a write-one-to-set word.
- Unmasking is done with a separate write-one-to-clear word.
- Priority words pack one 4-bit field per source.

After reset every source is masked and every priority is 0.

Top module: `intc_arbiter`

## Requirements
- R1: After reset (rst_ni low, asynchronous), all sources are masked, all priorities are 0, req_o is 0 and evt_code_o is 0. With every line asserted, no request is raised until masks are cleared.
- R2: A write to address 0 masks each source n whose data bit n is 1. Data bits that are 0 leave the mask state unchanged.
- R3: A write to address 1 unmasks each source n whose data bit n is 1. Data bits that are 0 leave the mask state unchanged.
- R4: A write to address 2+k loads the priority of source 8k+j from data bits [4j+3:4j].
- R5: Among the asserted, unmasked sources, the one with the highest priority level is selected.
- R6: When several candidates share the highest level, the lowest source index is selected.
- R7: A request is raised only when the selected level is strictly greater than cpu_level_i. An equal level raises nothing, and a level-0 source never raises a request.
- R8: req_o, req_level_o and req_code_o are registered. They reflect the inputs and the register state of the previous cycle. req_code_o equals 0x200 + 0x20·n for source n. With no request, req_level_o and req_code_o read 0.
- R9: A cycle with ack_i high while req_o is high loads evt_code_o with req_code_o. Otherwise evt_code_o holds its value, including when ack_i is high and req_o is low.
- R10: A source that loses arbitration remains pending. It is presented as soon as the winner's line drops, provided its line is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Level-sensitive request lines |
| cpu_level_i | input | PRIO_W | Current processor interrupt mask level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address (0 set, 1 clear, 2+ priority) |
| wr_data_i | input | DATA_W | Register write data |
| ack_i | input | 1 | Processor accepts the presented request |
| req_o | output | 1 | Request toward the processor |
| req_level_o | output | PRIO_W | Level of the presented request |
| req_code_o | output | CODE_W | Event code of the presented request |
| evt_code_o | output | CODE_W | Event code register of the last accepted request |

## Verification
The bench builds the block with 8 sources, 4-bit levels and a 32-bit data word. With these values the whole mask fits in one set or clear write, and all eight priorities fit in a single word. The arbitration tree is then a full three-level tree with no padded leaves. A fixed set of priorities contains two tied pairs, a level-0 source and the maximum level 9. This lets one vector table reach the tie order at two different levels, the equal-versus-greater boundary and the disabled source. Setting one field to 15 confirms that the field position maps to source 3.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned MASK_SET_ADDR  = 0;
  localparam int unsigned MASK_CLR_ADDR  = 1;
  localparam int unsigned PRIO_BASE_ADDR = 2;

  function automatic int unsigned event_code(int unsigned base, int unsigned step,
                                             int unsigned idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic [N_SRC-1:0]         mask_o,
  output logic [N_SRC*PRIO_W-1:0]  prio_o
);
  import intc_pkg::*;

  localparam int unsigned SRC_PER_REG = DATA_W / PRIO_W;

  logic [N_SRC-1:0] mask_q;
  logic             wr_set, wr_clr;

  assign wr_set = wr_en_i && (wr_addr_i == ADDR_W'(MASK_SET_ADDR));
  assign wr_clr = wr_en_i && (wr_addr_i == ADDR_W'(MASK_CLR_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (wr_set) begin
      mask_q <= mask_q | wr_data_i[N_SRC-1:0];
    end else if (wr_clr) begin
      mask_q <= mask_q & ~wr_data_i[N_SRC-1:0];
    end
  end

  assign mask_o = mask_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    localparam int unsigned REG_IDX = i / SRC_PER_REG;
    localparam int unsigned FLD_IDX = i % SRC_PER_REG;
    logic [PRIO_W-1:0] prio_q;
    logic              hit;

    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(PRIO_BASE_ADDR + REG_IDX));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q <= '0;
      end else if (hit) begin
        prio_q <= wr_data_i[FLD_IDX*PRIO_W +: PRIO_W];
      end
    end

    assign prio_o[i*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/intc_prio_tree.sv
module intc_prio_tree #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [N_SRC-1:0]         cand_i,
  input  logic [N_SRC*PRIO_W-1:0]  prio_i,
  output logic                     win_valid_o,
  output logic [PRIO_W-1:0]        win_level_o,
  output logic [IDX_W-1:0]         win_idx_o
);
  localparam int unsigned DEPTH  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned LEAVES = 1 << DEPTH;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] nl [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < N_SRC) begin : g_real
      assign nv[LEAVES-1+k] = cand_i[k];
      assign nl[LEAVES-1+k] = prio_i[k*PRIO_W +: PRIO_W];
    end else begin : g_pad
      assign nv[LEAVES-1+k] = 1'b0;
      assign nl[LEAVES-1+k] = '0;
    end
    assign ni[LEAVES-1+k] = IDX_W'(k);
  end

  // left child covers lower indices; >= keeps them on ties
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    logic pick_l;
    assign pick_l = nv[2*i+1] && (!nv[2*i+2] || (nl[2*i+1] >= nl[2*i+2]));
    assign nv[i]  = nv[2*i+1] || nv[2*i+2];
    assign nl[i]  = pick_l ? nl[2*i+1] : nl[2*i+2];
    assign ni[i]  = pick_l ? ni[2*i+1] : ni[2*i+2];
  end

  assign win_valid_o = nv[0];
  assign win_level_o = nl[0];
  assign win_idx_o   = ni[0];
endmodule

// File: rtl/intc_accept.sv
module intc_accept #(
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned CODE_BASE = 32'h200,
  parameter int unsigned CODE_STEP = 32'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_valid_i,
  input  logic [PRIO_W-1:0] win_level_i,
  input  logic [IDX_W-1:0]  win_idx_i,
  input  logic [PRIO_W-1:0] cpu_level_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [PRIO_W-1:0] req_level_o,
  output logic [CODE_W-1:0] req_code_o,
  output logic [CODE_W-1:0] evt_code_o
);
  import intc_pkg::*;

  logic              accept;
  logic [CODE_W-1:0] code_d;
  logic              req_q;
  logic [PRIO_W-1:0] lvl_q;
  logic [CODE_W-1:0] code_q, evt_q;

  assign accept = win_valid_i && (win_level_i > cpu_level_i);
  assign code_d = CODE_W'(event_code(CODE_BASE, CODE_STEP, int'(win_idx_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      lvl_q  <= '0;
      code_q <= '0;
      evt_q  <= '0;
    end else begin
      req_q  <= accept;
      lvl_q  <= accept ? win_level_i : '0;
      code_q <= accept ? code_d : '0;
      if (ack_i && req_q) evt_q <= code_q;
    end
  end

  assign req_o       = req_q;
  assign req_level_o = lvl_q;
  assign req_code_o  = code_q;
  assign evt_code_o  = evt_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned CODE_BASE = 32'h200,
  parameter int unsigned CODE_STEP = 32'h20,
  localparam int unsigned N_PRIO_REG = (N_SRC * PRIO_W + DATA_W - 1) / DATA_W,
  localparam int unsigned ADDR_W     = $clog2(intc_pkg::PRIO_BASE_ADDR + N_PRIO_REG),
  localparam int unsigned IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [PRIO_W-1:0] cpu_level_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [PRIO_W-1:0] req_level_o,
  output logic [CODE_W-1:0] req_code_o,
  output logic [CODE_W-1:0] evt_code_o
);
  logic [N_SRC-1:0]        mask;
  logic [N_SRC*PRIO_W-1:0] prio;
  logic [N_SRC-1:0]        cand;
  logic                    win_valid;
  logic [PRIO_W-1:0]       win_level;
  logic [IDX_W-1:0]        win_idx;

  intc_cfg_regs #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mask_o(mask), .prio_o(prio)
  );

  assign cand = irq_i & ~mask;

  intc_prio_tree #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_tree (
    .cand_i(cand), .prio_i(prio),
    .win_valid_o(win_valid), .win_level_o(win_level), .win_idx_o(win_idx)
  );

  intc_accept #(
    .PRIO_W(PRIO_W), .IDX_W(IDX_W), .CODE_W(CODE_W),
    .CODE_BASE(CODE_BASE), .CODE_STEP(CODE_STEP)
  ) u_acc (
    .clk_i, .rst_ni,
    .win_valid_i(win_valid), .win_level_i(win_level), .win_idx_i(win_idx),
    .cpu_level_i, .ack_i,
    .req_o, .req_level_o, .req_code_o, .evt_code_o
  );
endmodule

// File: rtl/intc_arbiter_chk.sv
module intc_arbiter_chk #(
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned CODE_BASE = 32'h200,
  parameter int unsigned CODE_STEP = 32'h20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  irq_i,
  input logic [PRIO_W-1:0] cpu_level_i,
  input logic              ack_i,
  input logic              req_o,
  input logic [PRIO_W-1:0] req_level_o,
  input logic [CODE_W-1:0] req_code_o,
  input logic [CODE_W-1:0] evt_code_o
);
  int chk_off;
  int chk_idx;
  assign chk_off = int'(req_code_o) - int'(CODE_BASE);
  assign chk_idx = chk_off / int'(CODE_STEP);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!req_o && evt_code_o == '0));

  assert_strict_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_level_o > $past(cpu_level_i)));

  assert_code_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (chk_off >= 0 && (chk_off % int'(CODE_STEP)) == 0 && chk_idx < int'(N_SRC)));

  assert_winner_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((($past(irq_i)) >> chk_idx) & N_SRC'(1)) != '0);

  assert_evt_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o) |=> (evt_code_o == $past(req_code_o)));

  assert_evt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && req_o) |=> $stable(evt_code_o));
endmodule

bind intc_arbiter intc_arbiter_chk #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .CODE_W(CODE_W),
  .CODE_BASE(CODE_BASE), .CODE_STEP(CODE_STEP)
) u_chk (.*);

// File: tb/tb_intc_arbiter.sv
`timescale 1ns/1ps
module tb_intc_arbiter;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_i = '0;
  logic [3:0]  cpu_level_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        ack_i = 1'b0;
  logic        req_o;
  logic [3:0]  req_level_o;
  logic [11:0] req_code_o, evt_code_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  intc_arbiter #(.N_SRC(N), .PRIO_W(4), .DATA_W(32), .CODE_W(12)) dut (.*);

  localparam logic [31:0] PRIO_WORD = 32'h9927_0553;
  int prio_tab [N] = '{3, 5, 5, 0, 7, 2, 9, 9};

  // {irq, cpu_level, expect_req, expect_src}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    20'h00_0_0_0, 20'h01_0_1_0, 20'h01_3_0_0, 20'h01_2_1_0,
    20'h06_0_1_1, 20'h08_0_0_0, 20'h13_4_1_4, 20'hC0_8_1_6,
    20'hC0_9_0_0, 20'h33_0_1_4, 20'h23_0_1_1, 20'h21_0_1_0,
    20'h20_1_1_5, 20'hFF_F_0_0
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    settle();
  endtask

  task automatic drive(logic [7:0] irq, logic [3:0] lvl);
    @(negedge clk_i);
    irq_i = irq; cpu_level_i = lvl;
    settle();
  endtask

  task automatic expect_src(string req, int src, int lvl);
    chk(req, int'(req_o), 1);
    chk(req, int'(req_code_o), 'h200 + 'h20 * src);
    chk(req, int'(req_level_o), lvl);
  endtask

  task automatic expect_none(string req);
    chk(req, int'(req_o), 0);
    chk(req, int'(req_code_o), 0);
    chk(req, int'(req_level_o), 0);
  endtask

  task automatic pulse_ack();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    expect_none("R1 reset");
    chk("R1 reset evt", int'(evt_code_o), 0);
    rst_ni = 1'b1;

    wr(2'd2, PRIO_WORD);
    drive(8'hFF, 4'd0);
    expect_none("R1 masked after reset");
    wr(2'd1, 32'h0);
    expect_none("R3 zero clear no effect");
    wr(2'd1, 32'hFF);
    expect_src("R6 clear all tie", 6, 9);
    wr(2'd0, 32'h0);
    expect_src("R2 zero set no effect", 6, 9);
    wr(2'd0, 32'h40);
    expect_src("R2 set masks src6", 7, 9);
    wr(2'd0, 32'h80);
    expect_src("R2 set masks src7", 4, 7);
    wr(2'd1, 32'h40);
    expect_src("R3 clear unmasks src6", 6, 9);
    wr(2'd1, 32'hFF);

    for (int v = 0; v < NV; v++) begin
      logic [19:0] e;
      e = VEC[v];
      drive(e[19:12], e[11:8]);
      if (e[4]) expect_src($sformatf("R5 R6 R7 vector %0d", v), int'(e[3:0]),
                           prio_tab[e[3:0]]);
      else expect_none($sformatf("R7 vector %0d", v));
    end

    wr(2'd2, 32'h9927_F553);
    drive(8'hFF, 4'd14);
    expect_src("R4 field of src3", 3, 15);
    wr(2'd2, PRIO_WORD);
    expect_none("R4 restore src3 level 0");

    drive(8'h11, 4'd0);
    expect_src("R10 winner src4", 4, 7);
    drive(8'h01, 4'd0);
    expect_src("R10 loser still pending", 0, 3);

    pulse_ack();
    chk("R9 ack loads code", int'(evt_code_o), 'h200);
    drive(8'h40, 4'd0);
    chk("R9 hold without ack", int'(evt_code_o), 'h200);
    drive(8'h00, 4'd0);
    pulse_ack();
    chk("R9 ack with no request", int'(evt_code_o), 'h200);
    drive(8'h40, 4'd0);
    pulse_ack();
    chk("R9 ack loads src6 code", int'(evt_code_o), 'h2C0);

    @(negedge clk_i);
    irq_i = 8'hFF;
    rst_ni = 1'b0;
    #1;
    expect_none("R1 async reset");
    chk("R1 async reset evt", int'(evt_code_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wr(2'd2, PRIO_WORD);
    expect_none("R1 remasked after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule